// File: doc/BRIEF.md
# Multi-Mode Timer Channel Counter

A single timer channel with one 16-bit counter whose start and count behaviour depend on a selected operating mode. In periodic mode it counts down from a reload value and signals each expiry. In pin-event mode it counts edges on an external pin. In period-capture mode it measures the time between rising pin edges. In one-shot mode it waits for a pin trigger and then runs one countdown. In pulse-width mode it waits for a rising pin edge and measures how long the pin stays high.

The counter advances only when a count-clock enable pulse arrives. A divider outside the block produces that pulse. Software starts and stops the channel with single-cycle strobes. In every mode except pin-event, the counter is not touched when the start strobe arrives. The first count-clock pulse after the start, or after the trigger, performs the initial load. Pin-event mode loads the reload value as soon as the start strobe is seen.

Top module: `mtc_channel`

## Requirements
- R1: After reset the counter, the capture register and the interrupt are 0, and the run flag is low.
- R2: A start strobe sets the run flag. In modes 0 (periodic), 2 (period-capture), 3 (one-shot) and 4 (pulse-width), the counter keeps its value until a count-clock pulse acts on it. Without a count-clock pulse the counter only changes on a start in mode 1.
- R3: In mode 0, the first count-clock pulse after start loads the reload value, and each later count-clock pulse decrements the counter.
- R4: In mode 0, a count-clock pulse that finds the counter at 0 reloads the reload value and raises the interrupt. With a count-clock pulse every cycle, the interrupt repeats every reload+1 cycles.
- R5: In mode 1 (pin-event), the start strobe loads the reload value in the cycle right after the strobe.
- R6: A pin edge is a count-clock pulse at which the pin level differs from its level at the previous count-clock pulse. In mode 1 the counter decrements only on a rising edge. Falling edges and count-clock pulses without an edge leave it unchanged.
- R7: In mode 1, a rising edge that finds the counter at 0 reloads the reload value and raises the interrupt.
- R8: In mode 2, the first count-clock pulse after start loads 0, and later count-clock pulses increment the counter.
- R9: In mode 2, a rising edge copies the counter into the capture register, restarts the count at 0 and raises the interrupt. A falling edge does not capture.
- R10: In modes 3 and 4, a start while stopped puts the channel into a trigger wait with the run flag high and the counter unchanged. A rising edge ends the wait, and the next count-clock pulse performs the load.
- R11: In mode 3 the load takes the reload value and count-clock pulses decrement it. The count-clock pulse that finds 0 raises the interrupt and returns the channel to the trigger wait with the counter held at 0.
- R12: In mode 4 the load takes 0 and count-clock pulses increment it. A falling edge copies the counter into the capture register, raises the interrupt, holds the counter and returns the channel to the trigger wait.
- R13: A stop strobe clears the run flag and freezes the counter at its current value. When start and stop arrive in the same cycle, stop wins. While stopped, count-clock pulses have no effect.
- R14: The interrupt is high only in the cycle right after a count-clock pulse, and it stays high for one cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable pulse |
| start_stb | input | 1 | Software start strobe |
| stop_stb | input | 1 | Software stop strobe |
| mode_sel | input | 3 | Mode: 0 periodic, 1 pin-event, 2 period-capture, 3 one-shot, 4 pulse-width; other codes act as 0 |
| reload_val | input | 16 | Reload (data) value |
| ext_in | input | 1 | External input pin |
| cnt_val | output | 16 | Current counter value |
| run_flag | output | 1 | Channel enabled |
| cap_val | output | 16 | Captured counter value |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checker watches every cycle for the rules that hold whatever the mode. Stop clears the run flag and freezes the counter. A stopped or start-only cycle leaves the counter alone, except for the immediate load in pin-event mode. The counter never moves without a count-clock pulse. The interrupt only follows a count-clock pulse. The load values, the count direction in each mode, the reload and capture values, the interrupt period and the return to the trigger wait all depend on sequences of pin edges and ticks. Only the bench's scenarios can show those.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [2:0] {
      MD_PERIODIC = 3'd0,
      MD_EVENT    = 3'd1,
      MD_CAPTURE  = 3'd2,
      MD_ONESHOT  = 3'd3,
      MD_WIDTH    = 3'd4
   } mtc_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARM,
      ST_LOAD,
      ST_RUN
   } mtc_state_e;

   typedef struct packed {
      logic load_data;
      logic load_zero;
      logic dec;
      logic inc;
      logic capture;
      logic irq;
   } mtc_op_t;

   function automatic mtc_mode_e decode_mode(input logic [MODE_W-1:0] raw);
      case (raw)
         3'd1:    decode_mode = MD_EVENT;
         3'd2:    decode_mode = MD_CAPTURE;
         3'd3:    decode_mode = MD_ONESHOT;
         3'd4:    decode_mode = MD_WIDTH;
         default: decode_mode = MD_PERIODIC;
      endcase
   endfunction

   function automatic logic counts_up(input mtc_mode_e m);
      counts_up = (m == MD_CAPTURE) || (m == MD_WIDTH);
   endfunction

endpackage

// File: rtl/mtc_edge.sv
module mtc_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin,
   output logic rise,
   output logic fall
);

   logic lvl;
   logic prev_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("mtc_edge: SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else if (SYNC_STAGES == 1) sync_q <= pin;
            else sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         end
         assign lvl = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   // level is remembered only at count-clock pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_q <= 1'b0;
      else if (tick) prev_q <= lvl;
   end

   assign rise = tick &  lvl & ~prev_q;
   assign fall = tick & ~lvl &  prev_q;

endmodule

// File: rtl/mtc_ctrl.sv
module mtc_ctrl
   import mtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start,
   input  logic       stop,
   input  mtc_mode_e  mode,
   input  logic       rise,
   input  logic       fall,
   input  logic       cnt_zero,
   output logic       running,
   output mtc_op_t    op
);

   mtc_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      op      = '0;
      if (stop) begin
         state_d = ST_IDLE;
      end else if (start) begin
         case (mode)
            MD_EVENT: begin
               op.load_data = 1'b1;
               state_d      = ST_RUN;
            end
            MD_ONESHOT, MD_WIDTH: begin
               if (state_q == ST_IDLE) state_d = ST_ARM;
            end
            default: state_d = ST_LOAD;
         endcase
      end else if (tick) begin
         case (state_q)
            ST_ARM: begin
               if (rise) state_d = ST_LOAD;
            end
            ST_LOAD: begin
               if (counts_up(mode)) op.load_zero = 1'b1;
               else                 op.load_data = 1'b1;
               state_d = ST_RUN;
            end
            ST_RUN: begin
               case (mode)
                  MD_EVENT: begin
                     if (rise) begin
                        if (cnt_zero) begin
                           op.load_data = 1'b1;
                           op.irq       = 1'b1;
                        end else begin
                           op.dec = 1'b1;
                        end
                     end
                  end
                  MD_CAPTURE: begin
                     if (rise) begin
                        op.capture   = 1'b1;
                        op.load_zero = 1'b1;
                        op.irq       = 1'b1;
                     end else begin
                        op.inc = 1'b1;
                     end
                  end
                  MD_ONESHOT: begin
                     if (cnt_zero) begin
                        op.irq  = 1'b1;
                        state_d = ST_ARM;
                     end else begin
                        op.dec = 1'b1;
                     end
                  end
                  MD_WIDTH: begin
                     if (fall) begin
                        op.capture = 1'b1;
                        op.irq     = 1'b1;
                        state_d    = ST_ARM;
                     end else begin
                        op.inc = 1'b1;
                     end
                  end
                  default: begin
                     if (cnt_zero) begin
                        op.load_data = 1'b1;
                        op.irq       = 1'b1;
                     end else begin
                        op.dec = 1'b1;
                     end
                  end
               endcase
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign running = (state_q != ST_IDLE);

endmodule

// File: rtl/mtc_datapath.sv
module mtc_datapath
   import mtc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mtc_op_t          op,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             cnt_zero,
   output logic             irq
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q, cap_q;
   logic             irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
      end else if (op.load_zero) begin
         cnt_q <= ZERO;
      end else if (op.load_data) begin
         cnt_q <= reload;
      end else if (op.dec) begin
         cnt_q <= cnt_q - ONE;
      end else if (op.inc) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q <= ZERO;
      else if (op.capture) cap_q <= cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= op.irq;
   end

   assign cnt      = cnt_q;
   assign cap      = cap_q;
   assign irq      = irq_q;
   assign cnt_zero = (cnt_q == ZERO);

endmodule

// File: rtl/mtc_channel.sv
module mtc_channel
   import mtc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              start_stb,
   input  logic              stop_stb,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic [CNT_W-1:0]  reload_val,
   input  logic              ext_in,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              run_flag,
   output logic [CNT_W-1:0]  cap_val,
   output logic              irq
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("mtc_channel: CNT_W must be at least 2");
      end
   endgenerate

   mtc_mode_e mode;
   mtc_op_t   op;
   logic      rise, fall, cnt_zero;

   assign mode = decode_mode(mode_sel);

   mtc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (cnt_tick),
      .pin   (ext_in),
      .rise  (rise),
      .fall  (fall)
   );

   mtc_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (cnt_tick),
      .start    (start_stb),
      .stop     (stop_stb),
      .mode     (mode),
      .rise     (rise),
      .fall     (fall),
      .cnt_zero (cnt_zero),
      .running  (run_flag),
      .op       (op)
   );

   mtc_datapath #(.CNT_W(CNT_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .reload   (reload_val),
      .cnt      (cnt_val),
      .cap      (cap_val),
      .cnt_zero (cnt_zero),
      .irq      (irq)
   );

endmodule

// File: rtl/mtc_channel_chk.sv
module mtc_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_tick,
   input logic             start_stb,
   input logic             stop_stb,
   input logic [2:0]       mode_sel,
   input logic [CNT_W-1:0] reload_val,
   input logic [CNT_W-1:0] cnt_val,
   input logic             run_flag,
   input logic             irq
);

   logic event_start;
   assign event_start = start_stb && !stop_stb && (mode_sel == 3'd1);

   AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb |=> !run_flag);                                         // R13

   AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb |=> (cnt_val == $past(cnt_val)));                       // R13

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_flag && !start_stb) |=> $stable(cnt_val));                 // R13

   AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_stb && !stop_stb) |=> run_flag);                          // R2

   AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_tick && !event_start) |=> $stable(cnt_val));               // R2

   AST_EVENT_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      event_start |=> (cnt_val == $past(reload_val)));                 // R5

   AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(cnt_tick));                                        // R14

endmodule

bind mtc_channel mtc_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt_tick   (cnt_tick),
   .start_stb  (start_stb),
   .stop_stb   (stop_stb),
   .mode_sel   (mode_sel),
   .reload_val (reload_val),
   .cnt_val    (cnt_val),
   .run_flag   (run_flag),
   .irq        (irq)
);

// File: tb/mtc_channel_tb.sv
`timescale 1ns/1ps
module mtc_channel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0, start_stb = 1'b0, stop_stb = 1'b0, ext_in = 1'b0;
   logic [2:0]  mode_sel = 3'd0;
   logic [15:0] reload_val = 16'd0;
   logic [15:0] cnt_val, cap_val;
   logic        run_flag, irq;
   int          checks = 0, errors = 0;

   always #4 clk = ~clk;

   mtc_channel u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .start_stb(start_stb),
      .stop_stb(stop_stb), .mode_sel(mode_sel), .reload_val(reload_val),
      .ext_in(ext_in), .cnt_val(cnt_val), .run_flag(run_flag),
      .cap_val(cap_val), .irq(irq)
   );

   // rows: reload value, expected interrupt period in cycles (R4)
   localparam int NVEC = 4;
   localparam int VEC[NVEC][2] = '{'{1, 2}, '{3, 4}, '{7, 8}, '{20, 21}};

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive one cycle of inputs, return after the edge at the next negedge
   task automatic cyc(input logic t, input logic s, input logic p, input logic e);
      cnt_tick = t; start_stb = s; stop_stb = p; ext_in = e;
      @(negedge clk);
   endtask

   task automatic measure_period(output int n);
      int guard = 0;
      while (!irq && guard < 200) begin cyc(1, 0, 0, 0); guard++; end
      n = 0;
      do begin cyc(1, 0, 0, 0); n++; end while (!irq && n < 200);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int per;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 cnt", cnt_val, 0);
      check("R1 run", run_flag, 0);
      check("R1 cap", cap_val, 0);
      check("R1 irq", irq, 0);

      // periodic mode: start does not load
      mode_sel = 3'd0; reload_val = 16'd5;
      cyc(0, 1, 0, 0);
      check("R2 run after start", run_flag, 1);
      check("R2 cnt untouched", cnt_val, 0);
      cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
      check("R2 no tick no load", cnt_val, 0);
      cyc(1, 0, 0, 0);
      check("R3 first tick loads", cnt_val, 5);
      cyc(1, 0, 0, 0);
      check("R3 decrement", cnt_val, 4);
      repeat (4) cyc(1, 0, 0, 0);
      check("R3 reaches zero", cnt_val, 0);
      check("R14 no irq before expiry", irq, 0);
      cyc(1, 0, 0, 0);
      check("R4 reload at zero", cnt_val, 5);
      check("R4 irq at zero", irq, 1);
      cyc(0, 0, 0, 0);
      check("R14 irq one cycle", irq, 0);

      // table of periodic reload values
      for (int i = 0; i < NVEC; i++) begin
         reload_val = 16'(VEC[i][0]);
         cyc(0, 0, 1, 0);
         cyc(0, 1, 0, 0);
         measure_period(per);
         check("R4 irq period", per, VEC[i][1]);
      end

      // stop freezes and wins over start
      reload_val = 16'd20;
      cyc(0, 0, 1, 0); cyc(0, 1, 0, 0);
      repeat (4) cyc(1, 0, 0, 0);
      check("R3 countdown", cnt_val, 17);
      cyc(0, 0, 1, 0);
      check("R13 stop clears run", run_flag, 0);
      repeat (3) cyc(1, 0, 0, 0);
      check("R13 frozen while stopped", cnt_val, 17);
      cyc(1, 1, 1, 0);
      check("R13 stop beats start", run_flag, 0);
      check("R13 cnt held", cnt_val, 17);

      // pin-event mode
      mode_sel = 3'd1; reload_val = 16'd3;
      cyc(0, 1, 0, 0);
      check("R5 immediate load", cnt_val, 3);
      cyc(1, 0, 0, 0);
      check("R6 no edge no count", cnt_val, 3);
      cyc(1, 0, 0, 1);
      check("R6 rising decrements", cnt_val, 2);
      cyc(1, 0, 0, 1);
      check("R6 steady high holds", cnt_val, 2);
      cyc(1, 0, 0, 0);
      check("R6 falling ignored", cnt_val, 2);
      cyc(1, 0, 0, 1); cyc(1, 0, 0, 0); cyc(1, 0, 0, 1);
      check("R6 count to zero", cnt_val, 0);
      cyc(1, 0, 0, 0);
      check("R7 no irq on falling", irq, 0);
      cyc(1, 0, 0, 1);
      check("R7 reload on edge", cnt_val, 3);
      check("R7 irq on edge", irq, 1);
      cyc(1, 0, 0, 0);

      // period-capture mode
      cyc(0, 0, 1, 0);
      mode_sel = 3'd2;
      cyc(0, 1, 0, 0);
      check("R2 capture start no load", cnt_val, 3);
      cyc(1, 0, 0, 0);
      check("R8 first tick loads zero", cnt_val, 0);
      repeat (4) cyc(1, 0, 0, 0);
      check("R8 increments", cnt_val, 4);
      cyc(1, 0, 0, 1);
      check("R9 captured", cap_val, 4);
      check("R9 restart", cnt_val, 0);
      check("R9 irq", irq, 1);
      cyc(1, 0, 0, 1);
      cyc(1, 0, 0, 0);
      check("R9 falling no capture", cap_val, 4);
      check("R9 keeps counting", cnt_val, 2);

      // one-shot mode
      cyc(0, 0, 1, 0);
      mode_sel = 3'd3; reload_val = 16'd6;
      cyc(0, 1, 0, 0);
      check("R10 run in wait", run_flag, 1);
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      check("R10 waiting holds cnt", cnt_val, 2);
      cyc(1, 0, 0, 1);
      check("R10 trigger no load yet", cnt_val, 2);
      cyc(1, 0, 0, 1);
      check("R11 load reload", cnt_val, 6);
      repeat (6) cyc(1, 0, 0, 1);
      check("R11 reached zero", cnt_val, 0);
      check("R11 no early irq", irq, 0);
      cyc(1, 0, 0, 1);
      check("R11 irq at end", irq, 1);
      cyc(1, 0, 0, 1);
      check("R11 back to wait", cnt_val, 0);
      check("R11 run stays", run_flag, 1);
      check("R14 single pulse", irq, 0);
      cyc(1, 0, 0, 0);

      // pulse-width mode
      cyc(0, 0, 1, 0);
      mode_sel = 3'd4;
      cyc(0, 1, 0, 0);
      cyc(1, 0, 0, 0);
      cyc(1, 0, 0, 1);
      cyc(1, 0, 0, 1);
      check("R12 load zero", cnt_val, 0);
      repeat (3) cyc(1, 0, 0, 1);
      check("R12 increments", cnt_val, 3);
      cyc(1, 0, 0, 0);
      check("R12 width captured", cap_val, 3);
      check("R12 irq", irq, 1);
      cyc(1, 0, 0, 0);
      check("R12 held in wait", cnt_val, 3);
      check("R12 run stays", run_flag, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule